// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This clocked block connects a host request port to an external asynchronous static RAM. The RAM holds 131072 words of 32 bits and is split into four byte lanes, each with its own active-low chip enable. A shared active-low write strobe, a shared active-low output enable and a tristate 32-bit data bus complete the memory side. For each request the host gives a word address, a read/write flag and a 4-bit byte mask. The controller then selects only the lanes named in the mask, steps the strobes through the read or write sequence, and returns a single-cycle acknowledge.

All timing is set by elaboration-time cycle counts: read access, write-data setup ahead of the strobe, strobe width, and a recovery gap after each access. These counts are rounded up from nanosecond limits to whole clock periods, and the defaults suit a 100 MHz clock. Bit i of the byte mask maps to lane i, and lane i carries data bits 8i+7 down to 8i. Read data for unselected lanes is returned as zero. The bus is handed between the RAM and the controller so that the two never drive it at once.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and after it is released with no request, all four chip enables, the write strobe and the output enable are high (inactive), the data-bus driver is off and ack is low.
- R2: During a read, chip enable i is low exactly when mask bit i is set. Output enable is low and the write strobe is high for RD_CYC cycles, and the latched address is presented on the address pins.
- R3: A read acknowledges on the clock edge that ends the RD_CYC-cycle access. The returned word holds the RAM byte on every lane whose mask bit is set and zero on every other lane.
- R4: During a write, the selected chip enables stay low for DSU_CYC+WE_CYC cycles and the write strobe is low for exactly WE_CYC of them. Output enable stays high for the whole write, and the chip enables do not change while the strobe is low.
- R5: The data-bus driver turns on only when output enable is high and was also high in the previous cycle. It is on for DSU_CYC cycles before the write strobe falls and for every cycle the strobe is low.
- R6: A request whose byte mask is 4'b0000 is acknowledged without any chip enable going low. A zero-mask read returns all zeros.
- R7: Each accepted request produces exactly one ack, and ack is high for a single cycle.
- R8: When the next request is already waiting, all chip enables stay high for exactly GAP_CYC sampled cycles between the ack of one request and the enables of the next. A request made from idle asserts its enables in the first cycle after acceptance.
- R9: A write changes only the RAM bytes of the lanes whose mask bits are set. Bytes of unselected lanes keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request present; sampled when the controller is idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 4 | Byte mask, bit i selects lane i (bits 8i+7:8i) |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | Single-cycle completion pulse |
| rdata | output | 32 | Read data, valid with ack of a read |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 4 | Per-lane active-low chip enables |
| mem_we_n | output | 1 | Shared active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_o | output | 32 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable of the controller's bus driver |
| mem_dq_i | input | 32 | Data sampled from the RAM bus |

## Verification
Two events can fall in the same cycle: the recovery gap of one access expires while a new request is already waiting, and the bus direction turns from a RAM-driven read to a controller-driven write. The bench provokes this by raising the next request in the same cycle that it sees the ack, and it mixes random reads and writes with random masks. It then counts the all-high enable cycles between the two accesses. It also flags any cycle in which the bus driver is on while output enable is low. A directed partial write followed by a full read confirms that unselected bytes survive.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int unsigned ADDR_W = 17;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WSTROBE,
    ST_RECOVER
  } ctrl_state_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_slice.sv
module sram_lane_slice #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              be_in,
  input  logic              ce_act_d,
  input  logic              cap,
  input  logic [LANE_W-1:0] dq_byte,
  output logic              ce_n,
  output logic [LANE_W-1:0] rbyte
);

  logic              be_q, be_d;
  logic              ce_n_q;
  logic [LANE_W-1:0] rbyte_q, rbyte_d;

  always_comb begin
    be_d    = accept ? be_in : be_q;
    rbyte_d = rbyte_q;
    if (cap) begin
      rbyte_d = be_d ? dq_byte : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q    <= 1'b0;
      ce_n_q  <= 1'b1;
      rbyte_q <= '0;
    end else begin
      be_q    <= be_d;
      ce_n_q  <= !(ce_act_d && be_d);
      rbyte_q <= rbyte_d;
    end
  end

  assign ce_n  = ce_n_q;
  assign rbyte = rbyte_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned NLANE   = LANES,
  parameter int unsigned LW      = LANE_W,
  parameter int unsigned RD_CYC  = 2,
  parameter int unsigned DSU_CYC = 1,
  parameter int unsigned WE_CYC  = 2,
  parameter int unsigned GAP_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_we,
  input  logic [AW-1:0]       req_addr,
  input  logic [NLANE-1:0]    req_be,
  input  logic [NLANE*LW-1:0] req_wdata,
  output logic                ack,
  output logic [NLANE*LW-1:0] rdata,
  output logic [AW-1:0]       mem_addr,
  output logic [NLANE-1:0]    mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [NLANE*LW-1:0] mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [NLANE*LW-1:0] mem_dq_i
);

  localparam int unsigned DW      = NLANE * LW;
  localparam int unsigned MAX_CYC = max4(RD_CYC, DSU_CYC, WE_CYC, GAP_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] DSU_LD = CNT_W'(DSU_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_l = rst_pipe[1];

  ctrl_state_e      state_q, state_d;
  logic             accept, cap, ack_d, ld, expired;
  logic [CNT_W-1:0] ld_val;
  logic             ce_act_d;
  logic             we_n_q, oe_n_q, drv_q, ack_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_l),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    accept  = 1'b0;
    cap     = 1'b0;
    ack_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (req_be == '0) begin
            state_d = ST_RECOVER;
            ld_val  = GAP_LD;
            ack_d   = 1'b1;
            cap     = !req_we;
          end else if (req_we) begin
            state_d = ST_WSETUP;
            ld_val  = DSU_LD;
          end else begin
            state_d = ST_READ;
            ld_val  = RD_LD;
          end
        end
      end
      ST_READ: begin
        if (expired) begin
          state_d = ST_RECOVER;
          ld      = 1'b1;
          ld_val  = GAP_LD;
          cap     = 1'b1;
          ack_d   = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (expired) begin
          state_d = ST_WSTROBE;
          ld      = 1'b1;
          ld_val  = WE_LD;
        end
      end
      ST_WSTROBE: begin
        if (expired) begin
          state_d = ST_RECOVER;
          ld      = 1'b1;
          ld_val  = GAP_LD;
          ack_d   = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ce_act_d = (state_d == ST_READ) || (state_d == ST_WSETUP) ||
                    (state_d == ST_WSTROBE);

  // registers: strobes are decoded from the next state so the pins are flop outputs
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_IDLE;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      we_n_q  <= (state_d != ST_WSTROBE);
      oe_n_q  <= (state_d != ST_READ);
      drv_q   <= (state_d == ST_WSETUP) || (state_d == ST_WSTROBE);
      ack_q   <= ack_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    sram_lane_slice #(.LANE_W(LW)) u_slice (
      .clk      (clk),
      .rst_n    (rst_l),
      .accept   (accept),
      .be_in    (req_be[g]),
      .ce_act_d (ce_act_d),
      .cap      (cap),
      .dq_byte  (mem_dq_i[g*LW +: LW]),
      .ce_n     (mem_ce_n[g]),
      .rbyte    (rdata[g*LW +: LW])
    );
  end

  assign ack       = ack_q;
  assign mem_addr  = addr_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = drv_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned NLANE  = 4,
  parameter int unsigned WE_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic [NLANE-1:0] mem_ce_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic             mem_dq_oe
);

  logic [7:0] wlow_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow_cnt <= '0;
    end else if (!mem_we_n) begin
      wlow_cnt <= wlow_cnt + 8'd1;
    end else begin
      wlow_cnt <= '0;
    end
  end

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  p_drive_in_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  p_read_has_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_ce_n != {NLANE{1'b1}}));

  p_write_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_ce_n != {NLANE{1'b1}}));

  p_ce_hold_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_ce_n));

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_cnt == 8'(WE_CYC)));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.NLANE(NLANE), .WE_CYC(WE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

  localparam int unsigned RD_C  = 2;
  localparam int unsigned DSU_C = 1;
  localparam int unsigned WE_C  = 2;
  localparam int unsigned GAP_C = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [16:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        ack;
  logic [31:0] rdata;
  logic [16:0] mem_addr;
  logic [3:0]  mem_ce_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_o;
  logic [31:0] mem_dq_i;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] last_rd;

  logic [31:0] sram    [logic [16:0]];
  logic [31:0] exp_mem [logic [16:0]];

  always #10 clk = ~clk;

  sram_lane_ctrl #(.RD_CYC(RD_C), .DSU_CYC(DSU_C), .WE_CYC(WE_C), .GAP_CYC(GAP_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  function automatic logic [31:0] sram_word(logic [16:0] a);
    return sram.exists(a) ? sram[a] : 32'h0;
  endfunction

  function automatic logic [31:0] exp_word(logic [16:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // behavioural RAM: pins are read away from the clock edge
  always @(negedge clk) begin
    logic [31:0] w;
    w = sram_word(mem_addr);
    if (!mem_we_n && mem_dq_oe) begin
      for (int i = 0; i < 4; i++)
        if (!mem_ce_n[i]) w[i*8 +: 8] = mem_dq_o[i*8 +: 8];
      sram[mem_addr] = w;
    end
    for (int i = 0; i < 4; i++)
      mem_dq_i[i*8 +: 8] = (!mem_ce_n[i] && !mem_oe_n && mem_we_n) ? w[i*8 +: 8] : 8'hA5;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic we, input logic [16:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input bit hold, input bit b2b);
    int n = 0, pre = 0, ce_low = 0, we_low = 0, oe_low = 0, drv_pre = 0;
    logic [3:0] ce_or = 4'h0;
    bit seen_ce = 0, seen_we = 0, got = 0, contention = 0;
    logic [31:0] rd = 32'h0;
    logic [31:0] expr;
    expr = exp_word(a) & lane_mask(be);
    req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      if (mem_ce_n != 4'hF) begin seen_ce = 1; ce_low++; end
      else if (!seen_ce) pre++;
      ce_or |= ~mem_ce_n;
      if (!mem_we_n) begin seen_we = 1; we_low++; end
      if (mem_dq_oe && !seen_we && mem_ce_n != 4'hF) drv_pre++;
      if (!mem_oe_n) oe_low++;
      if (mem_dq_oe && !mem_oe_n) contention = 1;
      if (!mem_oe_n && mem_ce_n != 4'hF) chk(mem_addr == a, "R2 address pins", 32'(mem_addr), 32'(a));
      if (ack) begin got = 1; rd = rdata; end
    end
    chk(got, "R7 ack seen", 32'(got), 32'd1);
    chk(ce_or == be, "R2 lanes enabled match mask", 32'(ce_or), 32'(be));
    chk(!contention, "R5 driver on while output enable low", 32'(contention), 32'd0);
    if (be == 4'h0) begin
      chk(ce_or == 4'h0, "R6 zero mask enables none", 32'(ce_or), 32'd0);
      if (!we) chk(rd == 32'h0, "R6 zero mask read data", rd, 32'h0);
    end else begin
      chk(pre == (b2b ? GAP_C : 0), "R8 enable gap", 32'(pre), 32'(b2b ? GAP_C : 0));
      if (!we) begin
        chk(oe_low == RD_C && ce_low == RD_C && we_low == 0, "R2 read strobe cycles",
            32'(oe_low), 32'(RD_C));
        chk(rd == expr, "R3 read data with masked lanes zero", rd, expr);
      end else begin
        chk(we_low == WE_C, "R4 write strobe width", 32'(we_low), 32'(WE_C));
        chk(oe_low == 0, "R4 output enable high in write", 32'(oe_low), 32'd0);
        chk(ce_low == DSU_C + WE_C, "R4 enable span", 32'(ce_low), 32'(DSU_C + WE_C));
        chk(drv_pre == DSU_C, "R5 data setup cycles", 32'(drv_pre), 32'(DSU_C));
        exp_mem[a] = (exp_word(a) & ~lane_mask(be)) | (wd & lane_mask(be));
      end
    end
    last_rd = rd;
    if (!hold) begin
      req = 1'b0;
      @(negedge clk);
      chk(!ack, "R7 ack single cycle", 32'(ack), 32'd0);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit prev_hold;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !ack,
        "R1 reset outputs", {26'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h3F);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_ce_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !ack,
        "R1 idle after reset", {26'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h3F);

    // R9 directed: partial write keeps the other lanes
    run_req(1'b1, 17'd5, 4'hF, 32'h11223344, 1'b0, 1'b0);
    run_req(1'b1, 17'd5, 4'b0101, 32'hAABBCCDD, 1'b0, 1'b0);
    run_req(1'b0, 17'd5, 4'hF, 32'h0, 1'b0, 1'b0);
    chk(last_rd == 32'h11BB33DD, "R9 unselected lanes unchanged", last_rd, 32'h11BB33DD);
    chk(sram_word(17'd5) == 32'h11BB33DD, "R9 ram contents", sram_word(17'd5), 32'h11BB33DD);

    // top address, then read-to-write turnaround with the next request waiting
    run_req(1'b1, 17'h1FFFF, 4'b1001, 32'hCAFEF00D, 1'b0, 1'b0);
    run_req(1'b0, 17'h1FFFF, 4'hF, 32'h0, 1'b1, 1'b0);
    run_req(1'b1, 17'h1FFFF, 4'b0110, 32'h12345678, 1'b1, 1'b1);
    run_req(1'b0, 17'h1FFFF, 4'b0111, 32'h0, 1'b0, 1'b1);
    run_req(1'b0, 17'd5, 4'h0, 32'h0, 1'b1, 1'b0);
    run_req(1'b1, 17'd5, 4'h0, 32'hFFFFFFFF, 1'b1, 1'b1);
    run_req(1'b0, 17'd5, 4'hF, 32'h0, 1'b0, 1'b1);
    chk(last_rd == 32'h11BB33DD, "R6 zero mask write left ram unchanged", last_rd, 32'h11BB33DD);

    prev_hold = 1'b0;
    for (int k = 0; k < 80; k++) begin
      logic [31:0] r;
      logic [16:0] a;
      bit h;
      r = $urandom;
      a = (r[1:0] == 2'd0) ? 17'd0 : (r[1:0] == 2'd1) ? 17'h1FFFF : {13'd0, r[5:2]};
      h = r[8];
      run_req(r[9], a, r[13:10], $urandom, h, prev_hold);
      prev_hold = h;
    end
    if (prev_hold) begin
      req = 1'b0;
      repeat (3) @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule